// File: doc/BRIEF.md
# Shared-Bus Rotary Encoder Scanner

This block serves a bank of eight push-button rotary encoders through eleven wires. The like contacts of every encoder (phase A, phase B, push switch) are tied together onto three pulled-up sense inputs. Each encoder's common terminal is fed by its own open-drain drive output. While nothing is turning, every drive is grounded. A falling edge on any sense line starts a timed binary search. The search releases groups of drives and watches whether the sense lines recover, which identifies the active encoder in three steps.

Once an encoder is found, all drives are grounded again. The sense lines then pass through digital integrating debouncers into a quadrature and button decoder. The decoder emits one-cycle step and button events tagged with the encoder index. The found encoder stays tracked for a programmable hold window after its last activity, so a fast spin is followed without repeated searches. Software reads the index together with each event.

Top module: `enc_bus_scanner`

## Requirements
- R1: After reset, and whenever no search runs, all bits of `drive_gnd_o` are 1 (every encoder grounded), `busy_o` is 0 and no event output pulses. Sense bit 0 is phase A, bit 1 is phase B and bit 2 is the push switch. A low sense bit means a closed contact.
- R2: While idle, a high-to-low change on any synchronized sense bit starts a search: `busy_o` rises, and the first probe releases encoders 0 to 3, so `drive_gnd_o` reads 8'hF0.
- R3: Each probe waits SETTLE_CYC cycles and then compares the synchronized sense bits with a snapshot taken when the search began. A difference places the encoder in the released half; no difference places it in the other half. Three probes select one encoder.
- R4: When the search ends, `enc_idx_o` holds the found encoder, every drive is grounded and `busy_o` falls. `enc_idx_o` changes only at the end of a search.
- R5: Each sense bit passes through a saturating integrator of DEB_W bits whose output flips only at full scale or zero. A contact pulse shorter than 2^DEB_W-1 cycles produces no event.
- R6: Debounced {A,B} phases follow the forward order 11, 01, 00, 10, 11. Each single-step move yields a one-cycle `step_vld_o`, with `step_dir_o` = 1 for forward and 0 for reverse, so one detent gives four steps.
- R7: A move in which A and B change together (for example 11 to 00) produces no step.
- R8: A debounced switch closure gives a one-cycle `btn_press_o`; its opening gives a one-cycle `btn_release_o`. The two never pulse in the same cycle.
- R9: Sense activity within HOLD_CYC cycles of the last activity is credited to the tracked encoder. No search starts and `enc_idx_o` is kept.
- R10: Activity after the hold window has expired starts a new search.
- R11: No step or button event pulses while `busy_o` is high. Debouncing is paused during a search, so a transition seen during a search is reported after it ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_i | input | 3 | Shared pulled-up sense bus: {switch, B, A}, low = closed |
| drive_gnd_o | output | 8 | Per-encoder drive enable: 1 pulls the common low, 0 releases it |
| enc_idx_o | output | 3 | Index of the tracked encoder |
| step_vld_o | output | 1 | One-cycle rotation step |
| step_dir_o | output | 1 | Step direction, 1 = forward |
| btn_press_o | output | 1 | One-cycle switch closure event |
| btn_release_o | output | 1 | One-cycle switch opening event |
| busy_o | output | 1 | High while a search runs |

## Verification
A rotation step and a button event can be reported in the same cycle. Phase A and the push switch share one integrator length, so when both contacts change together their debounced outputs flip in the same clock. The bench provokes this by closing A and the switch in the same cycle while the encoder is tracked, and later opening both together. It counts cycles in which `step_vld_o` and a button event are high together and expects two such cycles, along with one forward step, one reverse step, one press and one release.

// File: rtl/enc_scan_pkg.sv
package enc_scan_pkg;
  typedef enum logic [1:0] {
    SCAN_IDLE  = 2'd0,
    SCAN_PROBE = 2'd1,
    SCAN_TRACK = 2'd2
  } scan_state_e;

  localparam int SENSE_W = 3;
  localparam int SNS_A   = 0;
  localparam int SNS_B   = 1;
  localparam int SNS_SW  = 2;
endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '1;
      q_o    <= '1;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/enc_debounce.sv
module enc_debounce #(
  parameter int CW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic din_i,
  output logic dout_o
);
  localparam logic [CW-1:0] FULL = '1;

  logic [CW-1:0] acc_q, acc_nxt;

  always_comb begin
    acc_nxt = acc_q;
    if (!hold_i) begin
      if (din_i && acc_q != FULL)
        acc_nxt = acc_q + 1'b1;
      else if (!din_i && acc_q != '0)
        acc_nxt = acc_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= FULL;
      dout_o <= 1'b1;
    end else begin
      acc_q <= acc_nxt;
      if (acc_nxt == FULL)
        dout_o <= 1'b1;
      else if (acc_nxt == '0)
        dout_o <= 1'b0;
    end
  end
endmodule

// File: rtl/enc_quad_decode.sv
module enc_quad_decode (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic a_i,
  input  logic b_i,
  input  logic sw_i,
  output logic step_vld_o,
  output logic step_dir_o,
  output logic press_o,
  output logic release_o
);
  logic [1:0] ab_q;
  logic       sw_q;
  logic [1:0] ph_cur, ph_prev, ph_diff;

  function automatic logic [1:0] phase_of(input logic a, input logic b);
    return {~b, a ^ b};
  endfunction

  always_comb begin
    ph_cur  = phase_of(a_i, b_i);
    ph_prev = phase_of(ab_q[1], ab_q[0]);
    ph_diff = ph_cur - ph_prev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_q       <= 2'b11;
      sw_q       <= 1'b1;
      step_vld_o <= 1'b0;
      step_dir_o <= 1'b0;
      press_o    <= 1'b0;
      release_o  <= 1'b0;
    end else begin
      ab_q       <= {a_i, b_i};
      sw_q       <= sw_i;
      step_vld_o <= en_i && (ph_diff == 2'd1 || ph_diff == 2'd3);
      step_dir_o <= (ph_diff == 2'd1);
      press_o    <= en_i && sw_q && !sw_i;
      release_o  <= en_i && !sw_q && sw_i;
    end
  end
endmodule

// File: rtl/enc_search_fsm.sv
module enc_search_fsm
  import enc_scan_pkg::*;
#(
  parameter int N_ENC      = 8,
  parameter int SETTLE_CYC = 16,
  parameter int HOLD_CYC   = 8192,
  parameter int IDX_W      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SENSE_W-1:0] sense_s_i,
  input  logic               fall_i,
  input  logic               act_i,
  output logic [N_ENC-1:0]   drive_gnd_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               busy_o,
  output logic               track_o
);
  localparam int LVL_W  = (IDX_W > 1) ? $clog2(IDX_W) : 1;
  localparam int SET_W  = $clog2(SETTLE_CYC + 1);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam logic [LVL_W-1:0]  LAST_LVL = LVL_W'(IDX_W - 1);
  localparam logic [SET_W-1:0]  SET_LD   = SET_W'(SETTLE_CYC - 1);
  localparam logic [HOLD_W-1:0] HOLD_LD  = HOLD_W'(HOLD_CYC - 1);

  scan_state_e          state_q;
  logic [IDX_W-1:0]     base_q, base_nxt;
  logic [LVL_W-1:0]     lvl_q;
  logic [SET_W-1:0]     wait_q;
  logic [HOLD_W-1:0]    hold_q;
  logic [SENSE_W-1:0]   snap_q;
  int                   half, next_span;

  function automatic logic [N_ENC-1:0] probe_mask(input int b, input int span);
    logic [N_ENC-1:0] m;
    for (int i = 0; i < N_ENC; i++)
      m[i] = !(i >= b && i < b + span);
    return m;
  endfunction

  always_comb begin
    half      = N_ENC >> (int'(lvl_q) + 1);
    next_span = N_ENC >> (int'(lvl_q) + 2);
    base_nxt  = (sense_s_i != snap_q) ? base_q : IDX_W'(int'(base_q) + half);
  end

  assign track_o = (state_q == SCAN_TRACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SCAN_IDLE;
      base_q      <= '0;
      lvl_q       <= '0;
      wait_q      <= '0;
      hold_q      <= '0;
      snap_q      <= '1;
      drive_gnd_o <= '1;
      idx_o       <= '0;
      busy_o      <= 1'b0;
    end else begin
      unique case (state_q)
        SCAN_IDLE: begin
          if (fall_i) begin
            snap_q      <= sense_s_i;
            base_q      <= '0;
            lvl_q       <= '0;
            wait_q      <= SET_LD;
            drive_gnd_o <= probe_mask(0, N_ENC / 2);
            busy_o      <= 1'b1;
            state_q     <= SCAN_PROBE;
          end
        end
        SCAN_PROBE: begin
          if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
          end else if (lvl_q == LAST_LVL) begin
            idx_o       <= base_nxt;
            drive_gnd_o <= '1;
            busy_o      <= 1'b0;
            hold_q      <= HOLD_LD;
            state_q     <= SCAN_TRACK;
          end else begin
            base_q      <= base_nxt;
            lvl_q       <= lvl_q + 1'b1;
            wait_q      <= SET_LD;
            drive_gnd_o <= probe_mask(int'(base_nxt), next_span);
          end
        end
        SCAN_TRACK: begin
          if (act_i)
            hold_q <= HOLD_LD;
          else if (hold_q == '0)
            state_q <= SCAN_IDLE;
          else
            hold_q <= hold_q - 1'b1;
        end
        default: state_q <= SCAN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/enc_bus_scanner.sv
module enc_bus_scanner
  import enc_scan_pkg::*;
#(
  parameter int N_ENC      = 8,
  parameter int SETTLE_CYC = 16,
  parameter int HOLD_CYC   = 8192,
  parameter int DEB_W      = 4,
  parameter int IDX_W      = $clog2(N_ENC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       sense_i,
  output logic [N_ENC-1:0] drive_gnd_o,
  output logic [IDX_W-1:0] enc_idx_o,
  output logic             step_vld_o,
  output logic             step_dir_o,
  output logic             btn_press_o,
  output logic             btn_release_o,
  output logic             busy_o
);
  logic [SENSE_W-1:0] sense_s, sense_prev_q, sense_deb;
  logic               fall_evt, act_evt, tracking;

  enc_sync #(.W(SENSE_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (sense_i),
    .q_o (sense_s)
  );

  always_ff @(posedge clk) begin
    if (rst) sense_prev_q <= '1;
    else     sense_prev_q <= sense_s;
  end

  assign fall_evt = |(sense_prev_q & ~sense_s);
  assign act_evt  = (sense_prev_q != sense_s);

  for (genvar g = 0; g < SENSE_W; g++) begin : g_deb
    enc_debounce #(.CW(DEB_W)) u_deb (
      .clk    (clk),
      .rst    (rst),
      .hold_i (busy_o),
      .din_i  (sense_s[g]),
      .dout_o (sense_deb[g])
    );
  end

  enc_search_fsm #(
    .N_ENC      (N_ENC),
    .SETTLE_CYC (SETTLE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .IDX_W      (IDX_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .sense_s_i   (sense_s),
    .fall_i      (fall_evt),
    .act_i       (act_evt),
    .drive_gnd_o (drive_gnd_o),
    .idx_o       (enc_idx_o),
    .busy_o      (busy_o),
    .track_o     (tracking)
  );

  enc_quad_decode u_dec (
    .clk        (clk),
    .rst        (rst),
    .en_i       (tracking),
    .a_i        (sense_deb[SNS_A]),
    .b_i        (sense_deb[SNS_B]),
    .sw_i       (sense_deb[SNS_SW]),
    .step_vld_o (step_vld_o),
    .step_dir_o (step_dir_o),
    .press_o    (btn_press_o),
    .release_o  (btn_release_o)
  );
endmodule

// File: rtl/enc_bus_scanner_chk.sv
module enc_bus_scanner_chk #(
  parameter int N_ENC = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [N_ENC-1:0] drive_gnd_o,
  input logic [IDX_W-1:0] enc_idx_o,
  input logic             step_vld_o,
  input logic             btn_press_o,
  input logic             btn_release_o,
  input logic             busy_o
);
  assert_idle_grounded_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> drive_gnd_o == {N_ENC{1'b1}});

  assert_probe_releases_R3: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> drive_gnd_o != {N_ENC{1'b1}});

  assert_idx_held_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$past(busy_o) && !$past(rst)) |-> $stable(enc_idx_o));

  assert_btn_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({btn_press_o, btn_release_o}));

  assert_press_single_R8: assert property (@(posedge clk) disable iff (rst)
    btn_press_o |=> !btn_press_o);

  assert_quiet_in_search_R11: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !(step_vld_o || btn_press_o || btn_release_o));
endmodule

bind enc_bus_scanner enc_bus_scanner_chk #(.N_ENC(N_ENC), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .drive_gnd_o   (drive_gnd_o),
  .enc_idx_o     (enc_idx_o),
  .step_vld_o    (step_vld_o),
  .btn_press_o   (btn_press_o),
  .btn_release_o (btn_release_o),
  .busy_o        (busy_o)
);

// File: tb/enc_bus_scanner_bench.sv
`timescale 1ns/1ps
module enc_bus_scanner_bench;
  localparam int HOLD = 400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sense;
  logic [7:0] drive_gnd;
  logic [2:0] enc_idx;
  logic       step_vld, step_dir, btn_press, btn_release, busy;

  logic [7:0] a_cl = '0, b_cl = '0, s_cl = '0;
  assign sense = {~|(s_cl & drive_gnd), ~|(b_cl & drive_gnd), ~|(a_cl & drive_gnd)};

  always #4 clk = ~clk;

  enc_bus_scanner #(.HOLD_CYC(HOLD)) u_enc_bus_scanner (
    .clk           (clk),
    .rst           (rst),
    .sense_i       (sense),
    .drive_gnd_o   (drive_gnd),
    .enc_idx_o     (enc_idx),
    .step_vld_o    (step_vld),
    .step_dir_o    (step_dir),
    .btn_press_o   (btn_press),
    .btn_release_o (btn_release),
    .busy_o        (busy)
  );

  int n_fwd = 0, n_rev = 0, n_prs = 0, n_rel = 0, n_srch = 0, n_both = 0;
  logic busy_d = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (step_vld && step_dir)  n_fwd++;
      if (step_vld && !step_dir) n_rev++;
      if (btn_press)   n_prs++;
      if (btn_release) n_rel++;
      if (step_vld && (btn_press || btn_release)) n_both++;
      if (busy && !busy_d) n_srch++;
    end
    busy_d = busy;
  end

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ab(input int e, input logic [1:0] lv);
    a_cl[e] = ~lv[1];
    b_cl[e] = ~lv[0];
  endtask

  // One detent; levels {A,B}, forward order 11,01,00,10,11
  task automatic rotate(input int e, input bit fwd, input bit expect_search);
    logic [1:0] seq [4];
    if (fwd) seq = '{2'b01, 2'b00, 2'b10, 2'b11};
    else     seq = '{2'b10, 2'b00, 2'b01, 2'b11};
    set_ab(e, seq[0]);
    cyc(6);
    if (expect_search) begin
      chk(busy == 1'b1, "R2 busy", busy, 1);
      chk(drive_gnd == 8'hF0, "R2 first probe", drive_gnd, 8'hF0);
    end
    cyc(114);
    for (int k = 1; k < 4; k++) begin
      set_ab(e, seq[k]);
      cyc(40);
    end
    cyc(40);
  endtask

  // {encoder[2:0], forward, button}
  localparam logic [4:0] VEC [8] = '{
    {3'd7, 1'b1, 1'b1}, {3'd0, 1'b0, 1'b0}, {3'd3, 1'b1, 1'b0}, {3'd4, 1'b0, 1'b1},
    {3'd5, 1'b1, 1'b0}, {3'd2, 1'b0, 1'b0}, {3'd6, 1'b1, 1'b1}, {3'd1, 1'b0, 1'b1}
  };

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(3);
    chk(drive_gnd == 8'hFF, "R1 drives grounded", drive_gnd, 8'hFF);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(enc_idx == 3'd0, "R1 idx", enc_idx, 0);
    chk(!step_vld && !btn_press && !btn_release, "R1 events", step_vld, 0);

    for (int v = 0; v < 8; v++) begin
      int e, f0, r0, p0, l0, s0;
      bit fw, bt;
      e = int'(VEC[v][4:2]); fw = VEC[v][1]; bt = VEC[v][0];
      cyc(HOLD + 50);
      f0 = n_fwd; r0 = n_rev; s0 = n_srch;
      rotate(e, fw, 1'b1);
      chk(enc_idx == 3'(e), "R3 R4 index", enc_idx, e);
      chk(drive_gnd == 8'hFF && !busy, "R4 regrounded", drive_gnd, 8'hFF);
      chk(n_srch - s0 == 1, "R10 one search", n_srch - s0, 1);
      chk(n_fwd - f0 == (fw ? 4 : 0), "R6 forward steps", n_fwd - f0, fw ? 4 : 0);
      chk(n_rev - r0 == (fw ? 0 : 4), "R6 reverse steps", n_rev - r0, fw ? 0 : 4);
      if (bt) begin
        p0 = n_prs; l0 = n_rel;
        s_cl[e] = 1'b1; cyc(40);
        s_cl[e] = 1'b0; cyc(40);
        chk(n_prs - p0 == 1, "R8 press", n_prs - p0, 1);
        chk(n_rel - l0 == 1, "R8 release", n_rel - l0, 1);
      end
    end

    // R9: encoder 5 found, then encoder 2 moves inside the hold window
    begin
      int s0, f0;
      cyc(HOLD + 50);
      rotate(5, 1'b1, 1'b1);
      s0 = n_srch; f0 = n_fwd;
      rotate(2, 1'b1, 1'b0);
      chk(n_srch == s0, "R9 no search in hold", n_srch - s0, 0);
      chk(enc_idx == 3'd5, "R9 idx kept", enc_idx, 5);
      chk(n_fwd - f0 == 4, "R9 steps credited", n_fwd - f0, 4);
    end

    // R7: A and B change together
    begin
      int f0, r0;
      f0 = n_fwd; r0 = n_rev;
      set_ab(2, 2'b00); cyc(40);
      set_ab(2, 2'b11); cyc(40);
      chk((n_fwd - f0) + (n_rev - r0) == 0, "R7 double move", (n_fwd - f0) + (n_rev - r0), 0);
    end

    // R5: short switch pulse while tracked
    begin
      int p0, l0;
      p0 = n_prs; l0 = n_rel;
      s_cl[2] = 1'b1; cyc(3);
      s_cl[2] = 1'b0; cyc(40);
      chk(n_prs == p0 && n_rel == l0, "R5 glitch filtered", n_prs - p0, 0);
    end

    // Step and button in the same cycle
    begin
      int f0, r0, p0, l0, b0;
      f0 = n_fwd; r0 = n_rev; p0 = n_prs; l0 = n_rel; b0 = n_both;
      a_cl[2] = 1'b1; s_cl[2] = 1'b1; cyc(40);
      a_cl[2] = 1'b0; s_cl[2] = 1'b0; cyc(40);
      chk(n_both - b0 == 2, "R11 coincident events", n_both - b0, 2);
      chk(n_fwd - f0 == 1 && n_rev - r0 == 1, "R6 R11 steps", n_fwd - f0 + n_rev - r0, 2);
      chk(n_prs - p0 == 1 && n_rel - l0 == 1, "R8 R11 button", n_prs - p0 + n_rel - l0, 2);
    end

    // R10: after the window expires, encoder 2 triggers a new search
    begin
      int s0;
      cyc(HOLD + 50);
      s0 = n_srch;
      rotate(2, 1'b0, 1'b1);
      chk(n_srch - s0 == 1, "R10 fresh search", n_srch - s0, 1);
      chk(enc_idx == 3'd2, "R10 idx", enc_idx, 2);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule